// File: doc/BRIEF.md
# Periodic Down-Counter Timer with Compare

This block is a register-mapped periodic timer. A 32-bit counter steps down once per tick. A tick is produced from one of three clock-enable inputs, chosen by a control field, and then divided by a 12-bit prescaler. When the counter steps past zero it either reloads a software-written load value or wraps to all ones. A compare register is watched on every tick. A match sets a sticky flag, and that flag drives a level interrupt.

Software drives the block through a single-cycle synchronous register port. The port has a 3-bit word index, a write strobe, write data and combinational read data. Software can restart the count when the timer is enabled. It can force the counter with a load write. It can also issue a soft reset that keeps the enable and power-mode bits. The low-power mode bits and the debug bit are stored and read back only.

Top module: `periodic_cmp_timer`

## Requirements
- R1: Word index 0 is control, 1 status, 2 load, 3 compare and 4 count. Indices 5 to 7 read as zero and ignore writes. The count register ignores writes. After hard reset, load reads 0xFFFFFFFF and every other register reads 0.
- R2: Control writes store bits [25:0] and drop bits [31:26]. The bit layout is: 0 enable, 1 restart-on-enable, 2 compare interrupt enable, 3 reload mode, [15:4] prescaler, 16 soft reset, 17 overwrite, 18 to 21 stored-only mode bits, [25:24] clock source. Bit 16 is never stored and always reads 0.
- R3: A control write with bit 16 set stores only bits 0, 1 and 18 to 21 of the written value. It also clears status, compare, count and the prescaler, and sets load to 0xFFFFFFFF.
- R4: Clock source 01 takes its enables from ce_pclk, 10 from ce_hfclk and 11 from ce_32k. Source 00 produces no ticks. While the timer is enabled, a tick occurs on every (prescaler+1)-th cycle in which the selected enable is high.
- R5: On a tick the counter decrements. On a tick at zero it takes the load value when reload mode is 1, or 0xFFFFFFFF when reload mode is 0.
- R6: A control write that takes enable from 0 to 1 with restart-on-enable set loads the counter. It takes the load value if the written reload bit is 1 and 0xFFFFFFFF if it is 0. Without restart-on-enable the counter keeps its value.
- R7: A load write copies the written value into the counter only when the stored overwrite bit is 1. Otherwise the counter is untouched.
- R8: On a tick with the counter equal to compare and compare interrupt enable set, status bit 0 is set.
- R9: Writing status with bit 0 = 1 clears the flag, and writing 0 has no effect. If a set and a clear fall in the same cycle, the set wins.
- R10: irq is high exactly when the flag, compare interrupt enable and enable are all 1.
- R11: With enable at 0 the counter holds its value and the flag cannot be set.
- R12: A cycle with a control write produces no tick and restarts the prescaler from zero. A load overwrite in the same cycle as a tick wins over the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| addr | input | 3 | Register word index |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |
| ce_pclk | input | 1 | Clock enable of source 01 |
| ce_hfclk | input | 1 | Clock enable of source 10 |
| ce_32k | input | 1 | Clock enable of source 11 |
| irq | output | 1 | Level compare interrupt |

## Verification
The assertions assume that the clock-enable inputs and bus signals are valid, two-state values at every clock edge. They also assume that a control write and its effect on the counter are judged against the register values held before that edge. The bench drives every input on the falling edge and holds it through the following rising edge. It never lets an input go unknown after reset. It varies the enable patterns per source so that ignored sources are held high while the selected one toggles.

// File: rtl/periodic_cmp_timer.sv
`timescale 1ns/1ps
module periodic_cmp_timer #(
  parameter int TW = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        ce_pclk,
  input  logic        ce_hfclk,
  input  logic        ce_32k,
  output logic        irq
);
  localparam logic [25:0] KEEP_MASK = 26'h03C_0003;
  localparam logic [25:0] SWR_MASK  = 26'h001_0000;
  localparam logic [TW-1:0] ALL_ONES = '1;

  logic [25:0]   ctrl;
  logic          flag;
  logic [TW-1:0] load_q, cmp_q, count;
  logic [11:0]   psc;
  logic          src_ce;

  wire en     = ctrl[0];
  wire enmod  = ctrl[1];
  wire ocien  = ctrl[2];
  wire rld    = ctrl[3];
  wire [11:0] presc = ctrl[15:4];
  wire ovw    = ctrl[17];

  wire ctrl_wr = wr_en && addr == 3'd0;
  wire sts_wr  = wr_en && addr == 3'd1;
  wire ld_wr   = wr_en && addr == 3'd2;
  wire cmp_wr  = wr_en && addr == 3'd3;
  wire swr     = ctrl_wr && wr_data[16];
  wire restart = ctrl_wr && !en && wr_data[0] && wr_data[1];

  always_comb begin
    case (ctrl[25:24])
      2'b01:   src_ce = ce_pclk;
      2'b10:   src_ce = ce_hfclk;
      2'b11:   src_ce = ce_32k;
      default: src_ce = 1'b0;
    endcase
  end

  wire run  = en && src_ce && !ctrl_wr;
  wire tick = run && psc == presc;
  wire hit  = tick && ocien && count == cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       psc <= '0;
    else if (ctrl_wr) psc <= '0;
    else if (run)     psc <= tick ? '0 : psc + 12'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_wr) ctrl <= swr ? (wr_data[25:0] & KEEP_MASK) : (wr_data[25:0] & ~SWR_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   flag <= 1'b0;
    else if (swr)                 flag <= 1'b0;
    else if (hit)                 flag <= 1'b1;
    else if (sts_wr && wr_data[0]) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= ALL_ONES;
      cmp_q  <= '0;
    end else if (swr) begin
      load_q <= ALL_ONES;
      cmp_q  <= '0;
    end else begin
      if (ld_wr)  load_q <= wr_data[TW-1:0];
      if (cmp_wr) cmp_q  <= wr_data[TW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (swr)            count <= '0;
    else if (restart)        count <= wr_data[3] ? load_q : ALL_ONES;
    else if (ld_wr && ovw)   count <= wr_data[TW-1:0];
    else if (tick)           count <= (count == '0) ? (rld ? load_q : ALL_ONES) : count - 1'b1;
  end

  always_comb begin
    case (addr)
      3'd0:    rd_data = 32'(ctrl);
      3'd1:    rd_data = {31'd0, flag};
      3'd2:    rd_data = 32'(load_q);
      3'd3:    rd_data = 32'(cmp_q);
      3'd4:    rd_data = 32'(count);
      default: rd_data = '0;
    endcase
  end

  assign irq = flag && ocien && en;

  // R2
  swr_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) ctrl_wr |=> !ctrl[16]);

  // R3
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swr |=> (load_q == ALL_ONES && count == '0 && cmp_q == '0 && !flag && psc == '0));

  // R4
  psc_range_chk: assert property (@(posedge clk) disable iff (!rst_n) psc <= presc || $past(ctrl_wr));

  // R5
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count != '0 && !(ld_wr && ovw)) |=> count == $past(count) - 1'b1);

  // R5
  zero_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == '0 && !(ld_wr && ovw)) |=> count == ($past(rld) ? $past(load_q) : ALL_ONES));

  // R7
  overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_wr && ovw) |=> count == $past(wr_data[TW-1:0]));

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n) hit |=> flag);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && wr_data[0] && !hit) |=> !flag);

  // R11
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ctrl_wr && !ld_wr) |=> $stable(count));

  // R11
  no_set_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !flag) |=> !flag);

  // R1
  bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr > 3'd4 && !tick) |=> ($stable(ctrl) && $stable(load_q) && $stable(cmp_q) && $stable(count)));
endmodule

// File: tb/test_periodic_cmp_timer.sv
`timescale 1ns/1ps
module test_periodic_cmp_timer;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        ce_pclk = 1'b0, ce_hfclk = 1'b0, ce_32k = 1'b0;
  logic        irq;

  periodic_cmp_timer i_periodic_cmp_timer (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ce_pclk(ce_pclk), .ce_hfclk(ce_hfclk), .ce_32k(ce_32k), .irq(irq)
  );

  int vectors = 0, miscompares = 0;
  bit done = 0;
  string tag = "R1";

  logic [25:0] m_ctrl;
  logic        m_flag;
  logic [31:0] m_load, m_cmp, m_cnt;
  int          m_psc;

  function automatic void model_reset();
    m_ctrl = '0; m_flag = 0; m_load = 32'hFFFF_FFFF; m_cmp = 0; m_cnt = 0; m_psc = 0;
  endfunction

  function automatic logic [31:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return {6'd0, m_ctrl};
      3'd1: return {31'd0, m_flag};
      3'd2: return m_load;
      3'd3: return m_cmp;
      3'd4: return m_cnt;
      default: return 32'd0;
    endcase
  endfunction

  function automatic void model_step(logic [2:0] a, logic we, logic [31:0] d, logic [2:0] ce);
    bit ctrl_wr = we && a == 0;
    bit en = m_ctrl[0];
    bit sce = 0;
    bit tick = 0, setf = 0;
    logic [25:0] n_ctrl = m_ctrl;
    logic        n_flag = m_flag;
    logic [31:0] n_load = m_load, n_cmp = m_cmp, n_cnt = m_cnt;
    int          n_psc = m_psc;
    case (m_ctrl[25:24])
      2'd1: sce = ce[0];
      2'd2: sce = ce[1];
      2'd3: sce = ce[2];
      default: sce = 0;
    endcase
    if (en && sce && !ctrl_wr) begin
      if (m_psc == int'(m_ctrl[15:4])) begin tick = 1; n_psc = 0; end
      else n_psc = m_psc + 1;
    end
    if (tick) begin
      if (m_ctrl[2] && m_cnt == m_cmp) setf = 1;
      n_cnt = (m_cnt == 0) ? (m_ctrl[3] ? m_load : 32'hFFFF_FFFF) : m_cnt - 1;
    end
    if (setf) n_flag = 1;
    if (we) begin
      case (a)
        3'd0: begin
          n_psc = 0;
          if (d[16]) begin
            n_ctrl = d[25:0] & 26'h03C_0003;
            n_flag = 0; n_load = 32'hFFFF_FFFF; n_cmp = 0; n_cnt = 0;
          end else begin
            n_ctrl = d[25:0] & ~26'h001_0000;
            if (!en && d[0] && d[1]) n_cnt = d[3] ? m_load : 32'hFFFF_FFFF;
          end
        end
        3'd1: if (d[0] && !setf) n_flag = 0;
        3'd2: begin n_load = d; if (m_ctrl[17]) n_cnt = d; end
        3'd3: n_cmp = d;
        default: ;
      endcase
    end
    m_ctrl = n_ctrl; m_flag = n_flag; m_load = n_load; m_cmp = n_cmp; m_cnt = n_cnt; m_psc = n_psc;
  endfunction

  task automatic cyc(input logic [2:0] a, input logic we, input logic [31:0] d, input logic [2:0] ce);
    logic exp_irq;
    @(negedge clk);
    addr = a; wr_en = we; wr_data = d; {ce_32k, ce_hfclk, ce_pclk} = ce;
    #1;
    exp_irq = m_flag && m_ctrl[2] && m_ctrl[0];
    vectors++;
    if (rd_data !== exp_rd(a) || irq !== exp_irq) begin
      miscompares++;
      $display("FAIL %s: addr=%0d rd_data=%h irq=%b, expected rd_data=%h irq=%b",
               tag, a, rd_data, irq, exp_rd(a), exp_irq);
    end
    @(posedge clk);
    #1;
    if (rst_n) model_step(a, we, d, ce);
    else model_reset();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cyc(a, 1'b1, d, 3'b000);
  endtask

  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      logic [2:0] ce;
      case (mode)
        1: ce = {i % 2 == 0, 1'b1, 1'b1};
        2: ce = {1'b1, i % 3 == 0, 1'b1};
        3: ce = 3'b111;
        default: ce = 3'b001;
      endcase
      cyc((i % 3 == 0) ? 3'd1 : 3'd4, 1'b0, 32'd0, ce);
    end
  endtask

  task automatic read_all();
    for (int a = 0; a < 8; a++) cyc(3'(a), 1'b0, 32'd0, 3'b000);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    tag = "R1";
    cyc(3'd0, 1'b0, 32'd0, 3'b000);
    cyc(3'd2, 1'b0, 32'd0, 3'b000);
    @(negedge clk); rst_n = 1'b1;
    read_all();
    wr(3'd5, 32'hDEAD_BEEF); wr(3'd7, 32'h1234_5678); wr(3'd4, 32'd1234);
    read_all();

    tag = "R2";
    wr(3'd0, 32'hFFFE_FFFE);
    cyc(3'd0, 1'b0, 32'd0, 3'b000);
    wr(3'd0, 32'd0);

    tag = "R5 R8 R10";
    wr(3'd2, 32'd5); wr(3'd3, 32'd2);
    wr(3'd0, 32'h0100_000F);
    run(20, 0);

    tag = "R9";
    wr(3'd1, 32'd0);
    cyc(3'd1, 1'b0, 32'd0, 3'b001);
    wr(3'd1, 32'd1);
    for (int i = 0; i < 30; i++) begin
      if (i % 4 == 0) cyc(3'd1, 1'b1, 32'd1, 3'b001);
      else cyc(3'd1, 1'b0, 32'd0, 3'b001);
    end

    tag = "R4";
    wr(3'd0, 32'd0);
    wr(3'd0, 32'h0300_002F);
    run(40, 1);
    wr(3'd0, 32'd0);
    wr(3'd0, 32'h0200_000F);
    run(30, 2);
    wr(3'd0, 32'd0);
    wr(3'd0, 32'h0000_000F);
    run(10, 3);

    tag = "R5";
    wr(3'd0, 32'd0);
    wr(3'd0, 32'h0002_0000);
    tag = "R7";
    wr(3'd2, 32'd3);
    cyc(3'd4, 1'b0, 32'd0, 3'b001);
    tag = "R5";
    wr(3'd0, 32'h0102_0005);
    run(12, 0);
    tag = "R7";
    wr(3'd2, 32'd10);
    run(3, 0);
    wr(3'd0, 32'h0100_0005);
    wr(3'd2, 32'd50);
    run(5, 0);
    tag = "R12";
    wr(3'd0, 32'h0102_0005);
    run(2, 0);
    cyc(3'd2, 1'b1, 32'd20, 3'b001);
    run(3, 0);

    tag = "R6";
    wr(3'd0, 32'd0);
    wr(3'd0, 32'h0100_000B);
    run(5, 0);
    wr(3'd0, 32'd0);
    wr(3'd0, 32'h0100_0003);
    run(3, 0);
    wr(3'd0, 32'd0);
    wr(3'd0, 32'h0100_0001);
    run(3, 0);

    tag = "R11";
    wr(3'd1, 32'd1);
    wr(3'd0, 32'h0100_0004);
    wr(3'd3, m_cnt);
    run(10, 3);

    tag = "R12";
    for (int i = 0; i < 12; i++) begin
      if (i % 2 == 1) cyc(3'd0, 1'b1, 32'h0100_0025, 3'b001);
      else cyc(3'd4, 1'b0, 32'd0, 3'b001);
    end
    run(9, 0);

    tag = "R3";
    wr(3'd3, 32'd7);
    wr(3'd0, 32'h033F_FFFF);
    read_all();
    run(5, 3);

    done = 1;
    summary();
    $finish;
  end
endmodule